// File: doc/BRIEF.md
# Shadow-Context Scan Configuration Controller

This block holds the configuration of a row of reconfigurable resources. Each resource owns a working configuration word, which drives the datapath, and a paired shadow word. The shadow words of one domain are linked into a serial shift chain. A multi-bit word enters at the chain head on each shift, and the word at the tail is visible on the domain's serial output. A new context can therefore be streamed in while the working words keep the datapath steady.

A single global swap strobe exchanges every shadow word with its working word in one clock cycle. The exchange is two-way, so the context that was running lands in the shadow chain. It can then be streamed out for preemption while the next context streams in behind it. The row is split into several domains. Each domain has its own shift enable, serial input and serial output, so all domains load at the same time. A per-domain flag reports that a full context has been shifted in since the last swap.

Top module: `ctx_scan_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, all working words, all shadow words (seen on the serial outputs) and all loaded flags are zero.
- R2: The word at a domain's serial input is taken into cell 0 on each cycle in which that domain's shift enable is high. Each shift moves every shadow word one cell toward the tail. The serial output shows the shadow word of the last cell, so a word appears there after REGS_PER_DOMAIN shifts.
- R3: Shifting never changes any working word. The working bus changes only in a swap cycle.
- R4: On a swap cycle every working word takes its shadow word, and every shadow word takes the previous working word, with both due one cycle later.
- R5: After a swap, shifting a domain presents the displaced context on its serial output, starting with the last cell's old working word, then the next cell's, and so on.
- R6: A domain whose shift enable is low, in a cycle without a swap, keeps its shadow chain and serial output unchanged, whatever the other domains do.
- R7: When swap and a shift enable are both high, only the swap happens and that domain does not shift.
- R8: A domain's loaded flag rises once REGS_PER_DOMAIN shifts have happened since the last swap or reset. It stays high through further shifts and is cleared by a swap.
- R9: A swap whose shadow contents equal the working contents leaves every working word unchanged, with no transient change on the working bus.
- R10: Working word i of domain d sits at active_cfg_o bits [(d*REGS_PER_DOMAIN+i)*WORD_WIDTH +: WORD_WIDTH]. Cell 0 is nearest the serial input. Domain d's serial input and output use bits [d*WORD_WIDTH +: WORD_WIDTH].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_i | input | 1 | Global exchange strobe for shadow and working words |
| shift_en_i | input | NUM_DOMAINS | Per-domain shift enable |
| cfg_in_i | input | NUM_DOMAINS*WORD_WIDTH | Per-domain serial input word |
| cfg_out_o | output | NUM_DOMAINS*WORD_WIDTH | Per-domain serial output (tail shadow word) |
| active_cfg_o | output | NUM_DOMAINS*REGS_PER_DOMAIN*WORD_WIDTH | All working configuration words |
| loaded_o | output | NUM_DOMAINS | Per-domain full-context-loaded flag |

## Verification
Every result here is registered exactly once. A shift, a swap or a flag update applied before a rising edge is visible on the outputs right after that edge, and the serial output lags a word's entry by REGS_PER_DOMAIN shift cycles. The bench drives inputs on the falling edge and checks on the next falling edge, so each check sees the state one edge after its stimulus. A cycle-by-cycle vector table covers loading, swapping, the swap-over-shift priority and shifting out. Directed steps then check the whole working bus during shifts, an equal-context swap monitored for any change on the bus, and reset.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  // Operation applied to one shadow/working pair in a cycle.
  typedef enum logic [1:0] {
    CELL_HOLD  = 2'd0,
    CELL_SHIFT = 2'd1,
    CELL_SWAP  = 2'd2
  } cell_op_e;

endpackage

// File: rtl/ctx_cell.sv
module ctx_cell
  import ctx_pkg::*;
#(
  parameter int WORD_WIDTH = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  cell_op_e              op_i,
  input  logic [WORD_WIDTH-1:0] shift_in_i,
  output logic [WORD_WIDTH-1:0] shadow_o,
  output logic [WORD_WIDTH-1:0] active_o
);

  logic [WORD_WIDTH-1:0] shadow_q, shadow_d;
  logic [WORD_WIDTH-1:0] active_q, active_d;

  always_comb begin
    shadow_d = shadow_q;
    active_d = active_q;
    unique case (op_i)
      CELL_SHIFT: shadow_d = shift_in_i;
      CELL_SWAP: begin
        shadow_d = active_q;
        active_d = shadow_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

  // R4: two-way exchange in one cycle
  p_swap_exchange_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == CELL_SWAP) |=> (active_q == $past(shadow_q)) && (shadow_q == $past(active_q)));

  // R2: a shift takes the neighbour's word
  p_shift_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == CELL_SHIFT) |=> (shadow_q == $past(shift_in_i)));

  // R3: working word moves only on swap
  p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != CELL_SWAP) |=> $stable(active_q));

  // R9: equal-content swap keeps the working word
  p_eq_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == CELL_SWAP && shadow_q == active_q) |=> $stable(active_q));

endmodule

// File: rtl/ctx_domain.sv
module ctx_domain
  import ctx_pkg::*;
#(
  parameter int REGS_PER_DOMAIN = 4,
  parameter int WORD_WIDTH      = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  swap_i,
  input  logic                                  shift_en_i,
  input  logic [WORD_WIDTH-1:0]                 cfg_in_i,
  output logic [WORD_WIDTH-1:0]                 cfg_out_o,
  output logic [REGS_PER_DOMAIN*WORD_WIDTH-1:0] active_o,
  output logic                                  loaded_o
);

  localparam int CW = $clog2(REGS_PER_DOMAIN + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(REGS_PER_DOMAIN);

  cell_op_e              op;
  logic [WORD_WIDTH-1:0] shadow [REGS_PER_DOMAIN];
  logic [CW-1:0]         cnt_q, cnt_d;

  // Swap outranks shift (R7)
  always_comb begin
    if (swap_i)          op = CELL_SWAP;
    else if (shift_en_i) op = CELL_SHIFT;
    else                 op = CELL_HOLD;
  end

  for (genvar i = 0; i < REGS_PER_DOMAIN; i++) begin : g_cell
    logic [WORD_WIDTH-1:0] link_in;
    if (i == 0) begin : g_head
      assign link_in = cfg_in_i;
    end else begin : g_body
      assign link_in = shadow[i-1];
    end
    ctx_cell #(.WORD_WIDTH(WORD_WIDTH)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .shift_in_i (link_in),
      .shadow_o   (shadow[i]),
      .active_o   (active_o[i*WORD_WIDTH +: WORD_WIDTH])
    );
  end

  assign cfg_out_o = shadow[REGS_PER_DOMAIN-1];

  // Shift counter for the loaded flag
  always_comb begin
    cnt_d = cnt_q;
    if (op == CELL_SWAP)
      cnt_d = '0;
    else if (op == CELL_SHIFT && cnt_q != FULL_CNT)
      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign loaded_o = (cnt_q == FULL_CNT);

  // R8: swap clears the flag
  p_loaded_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_i |=> !loaded_o);

  // R8: once set, further shifts keep it set
  p_loaded_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_o && !swap_i) |=> loaded_o);

  // R7: swap with shift: tail gets the old working word, not a shifted one
  p_swap_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_i && shift_en_i) |=>
      (cfg_out_o == $past(active_o[(REGS_PER_DOMAIN-1)*WORD_WIDTH +: WORD_WIDTH])));

  // R3: the whole working bus is steady outside swaps
  p_bus_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_i |=> $stable(active_o));

endmodule

// File: rtl/ctx_scan_ctrl.sv
module ctx_scan_ctrl
  import ctx_pkg::*;
#(
  parameter int NUM_DOMAINS     = 2,
  parameter int REGS_PER_DOMAIN = 4,
  parameter int WORD_WIDTH      = 6
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              swap_i,
  input  logic [NUM_DOMAINS-1:0]                            shift_en_i,
  input  logic [NUM_DOMAINS*WORD_WIDTH-1:0]                 cfg_in_i,
  output logic [NUM_DOMAINS*WORD_WIDTH-1:0]                 cfg_out_o,
  output logic [NUM_DOMAINS*REGS_PER_DOMAIN*WORD_WIDTH-1:0] active_cfg_o,
  output logic [NUM_DOMAINS-1:0]                            loaded_o
);

  localparam int DOM_BITS = REGS_PER_DOMAIN * WORD_WIDTH;

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    ctx_domain #(
      .REGS_PER_DOMAIN (REGS_PER_DOMAIN),
      .WORD_WIDTH      (WORD_WIDTH)
    ) u_domain (
      .clk        (clk),
      .rst_n      (rst_n),
      .swap_i     (swap_i),
      .shift_en_i (shift_en_i[d]),
      .cfg_in_i   (cfg_in_i[d*WORD_WIDTH +: WORD_WIDTH]),
      .cfg_out_o  (cfg_out_o[d*WORD_WIDTH +: WORD_WIDTH]),
      .active_o   (active_cfg_o[d*DOM_BITS +: DOM_BITS]),
      .loaded_o   (loaded_o[d])
    );

    // R6: an idle domain is untouched by the others
    p_idle_domain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!swap_i && !shift_en_i[d]) |=>
        ($stable(cfg_out_o[d*WORD_WIDTH +: WORD_WIDTH]) && $stable(loaded_o[d])));
  end

endmodule

// File: tb/ctx_scan_ctrl_tb.sv
`timescale 1ns/1ps
module ctx_scan_ctrl_tb;

  localparam int ND = 2;
  localparam int RP = 4;
  localparam int W  = 6;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 swap;
  logic [ND-1:0]        shen;
  logic [ND*W-1:0]      cin;
  logic [ND*W-1:0]      cout;
  logic [ND*RP*W-1:0]   act;
  logic [ND-1:0]        ld;

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  bit mon = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctx_scan_ctrl #(.NUM_DOMAINS(ND), .REGS_PER_DOMAIN(RP), .WORD_WIDTH(W)) u_dut (
    .clk (clk), .rst_n (rst_n), .swap_i (swap), .shift_en_i (shen),
    .cfg_in_i (cin), .cfg_out_o (cout), .active_cfg_o (act), .loaded_o (ld)
  );

  always @(act) if (mon) glitches++;

  typedef struct packed {
    logic [1:0] sh;
    logic       sw;
    logic [5:0] in0, in1, out0, out1;
    logic [1:0] ld;
    logic [5:0] a0, a1;
  } row_t;

  // a0/a1: working word of cell 3 in domain 0/1
  localparam row_t TBL [16] = '{
    '{2'b11, 1'b0, 6'd1, 6'd33, 6'd0, 6'd0,  2'b00, 6'd0, 6'd0},
    '{2'b01, 1'b0, 6'd2, 6'd0,  6'd0, 6'd0,  2'b00, 6'd0, 6'd0},
    '{2'b11, 1'b0, 6'd3, 6'd34, 6'd0, 6'd0,  2'b00, 6'd0, 6'd0},
    '{2'b01, 1'b0, 6'd4, 6'd0,  6'd1, 6'd0,  2'b01, 6'd0, 6'd0},
    '{2'b10, 1'b0, 6'd0, 6'd35, 6'd1, 6'd0,  2'b01, 6'd0, 6'd0},
    '{2'b10, 1'b0, 6'd0, 6'd36, 6'd1, 6'd33, 2'b11, 6'd0, 6'd0},
    '{2'b11, 1'b0, 6'd5, 6'd37, 6'd2, 6'd34, 2'b11, 6'd0, 6'd0},
    '{2'b11, 1'b1, 6'd9, 6'd9,  6'd0, 6'd0,  2'b00, 6'd2, 6'd34},
    '{2'b11, 1'b0, 6'd6, 6'd38, 6'd0, 6'd0,  2'b00, 6'd2, 6'd34},
    '{2'b11, 1'b0, 6'd7, 6'd39, 6'd0, 6'd0,  2'b00, 6'd2, 6'd34},
    '{2'b11, 1'b0, 6'd8, 6'd40, 6'd0, 6'd0,  2'b00, 6'd2, 6'd34},
    '{2'b11, 1'b0, 6'd9, 6'd41, 6'd6, 6'd38, 2'b11, 6'd2, 6'd34},
    '{2'b00, 1'b1, 6'd0, 6'd0,  6'd2, 6'd34, 2'b00, 6'd6, 6'd38},
    '{2'b11, 1'b0, 6'd0, 6'd0,  6'd3, 6'd35, 2'b00, 6'd6, 6'd38},
    '{2'b00, 1'b0, 6'd0, 6'd0,  6'd3, 6'd35, 2'b00, 6'd6, 6'd38},
    '{2'b01, 1'b0, 6'd0, 6'd0,  6'd4, 6'd35, 2'b00, 6'd6, 6'd38}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // inputs applied at a falling edge, results read at the next falling edge
  task automatic cyc(input logic [1:0] sh, input logic sw, input logic [5:0] i0, input logic [5:0] i1);
    shen = sh; swap = sw; cin = {i1, i0};
    @(negedge clk);
    shen = '0; swap = 1'b0; cin = '0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [ND*RP*W-1:0] exp_act;
    rst_n = 1'b0; swap = 1'b0; shen = '0; cin = '0;
    repeat (3) @(negedge clk);
    chk("R1 active in reset", act, '0);
    chk("R1 out in reset", cout, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 loaded after reset", ld, '0);
    chk("R1 active after reset", act, '0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8 R10
    for (int k = 0; k < 16; k++) begin
      cyc(TBL[k].sh, TBL[k].sw, TBL[k].in0, TBL[k].in1);
      chk($sformatf("R2 R5 R6 R7 out0 row %0d", k), cout[0 +: W], TBL[k].out0);
      chk($sformatf("R2 R5 R6 R7 out1 row %0d", k), cout[W +: W], TBL[k].out1);
      chk($sformatf("R8 loaded row %0d", k), ld, TBL[k].ld);
      chk($sformatf("R3 R4 act0 row %0d", k), act[3*W +: W], TBL[k].a0);
      chk($sformatf("R3 R4 act1 row %0d", k), act[7*W +: W], TBL[k].a1);
    end

    // R4 R10: full working bus after another swap
    cyc(2'b00, 1'b1, 6'd0, 6'd0);
    exp_act = {6'd35, 6'd36, 6'd37, 6'd0, 6'd4, 6'd5, 6'd0, 6'd0};
    chk("R4 R10 full bus after swap", act, exp_act);
    chk("R4 R5 out after swap", cout, {6'd38, 6'd6});

    // R3: load a copy of the working context, bus must stay put
    cyc(2'b11, 1'b0, 6'd4, 6'd35);
    chk("R3 bus steady shift 1", act, exp_act);
    cyc(2'b11, 1'b0, 6'd5, 6'd36);
    chk("R3 bus steady shift 2", act, exp_act);
    cyc(2'b11, 1'b0, 6'd0, 6'd37);
    chk("R3 bus steady shift 3", act, exp_act);
    cyc(2'b11, 1'b0, 6'd0, 6'd0);
    chk("R3 bus steady shift 4", act, exp_act);
    chk("R8 loaded after full load", ld, 2'b11);
    chk("R2 tail after reload", cout, {6'd35, 6'd4});

    // R9: equal-context swap, watch for any bus change
    glitches = 0;
    mon = 1'b1;
    cyc(2'b00, 1'b1, 6'd0, 6'd0);
    @(negedge clk);
    mon = 1'b0;
    chk("R9 no bus change on equal swap", 64'(glitches), 64'd0);
    chk("R9 bus value on equal swap", act, exp_act);
    chk("R9 R8 loaded cleared", ld, 2'b00);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 active on mid reset", act, '0);
    chk("R1 out on mid reset", cout, '0);
    chk("R1 loaded on mid reset", ld, '0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
  end

endmodule